// File: doc/BRIEF.md
# Single-line bus master with identity reader

This block is a bus master for a single-wire, open-drain device bus of the 1-Wire kind. The line has an external pull-up. The master only pulls it low, through the output enable `ow_oe`, or lets it go. It reads the line back on `ow_in`, through a two-flop synchronizer. All slot timing is counted in microsecond ticks. A prescaler makes these ticks by dividing the system clock by `CLK_PER_US`.

A command is a one-cycle `cmd_valid` with a 2-bit `cmd_op`. There are four operations:

- **Bus reset.** A reset pulse followed by presence detection.
- **Write byte.** Sends the byte on `cmd_wdata`.
- **Read byte.** Receives one byte into `rd_data`.
- **Identity read.** A self-running sequence. It resets the bus and sends the identity command code 0x33. It then collects 64 bits: the family byte, a 48-bit serial number and a check byte.

`busy` covers the whole operation, and `done` marks its end.

Top module: `owire_rom_master`

## Requirements
- R1: While `rst_n` is low, and after it is released with no command, `ow_oe`, `busy`, `done` and `presence` are 0, and `rd_data`, `rom_family`, `rom_serial` and `rom_crc` are zero.
- R2: A bus reset slot lasts 960 µs.
  - The line is driven low for exactly 480 µs.
  - The line is sampled 70 µs after release. `presence` becomes 1 if the line was low at that instant and 0 if it was high.
- R3: A write-1 slot drives the line low for exactly 6 µs. Every bit slot (write or read) lasts 70 µs, so consecutive slot starts are 70 µs apart.
- R4: A write-0 slot drives the line low for exactly 60 µs and then releases it for the remaining 10 µs of the slot.
- R5: With `cmd_op`=1, the block sends `cmd_wdata` as eight bit slots, least significant bit first.
- R6: With `cmd_op`=2, the block runs eight read slots.
  - Each slot drives the line low for 6 µs.
  - The line is sampled 15 µs after the slot starts. A low level reads as 0 and a high level as 1.
  - Bits fill `rd_data` least significant first. `rd_data` is updated when `done` pulses.
- R7: Command handling and status:
  - `cmd_op` codes: 0 = bus reset, 1 = write byte, 2 = read byte, 3 = identity read.
  - A command is accepted when `cmd_valid` is high and `busy` is low.
  - `busy` rises on the next cycle and stays high for exactly (number of slots × slot length) clock cycles.
  - `done` is then high for exactly one cycle, with `busy` low.
- R8: `cmd_valid` while `busy` is high is ignored. The running operation keeps its length and result, and no extra slot follows it.
- R9: With `cmd_op`=3, the block runs the following, in this order:
  - one reset slot, which updates `presence`;
  - the byte 0x33, least significant bit first;
  - 64 read slots.
  
  The 64 bits received, taken least significant first, are placed as follows:
  - the first byte goes to `rom_family`;
  - the next six bytes go to `rom_serial`, with the first of them in bits 7:0;
  - the last byte goes to `rom_crc` and also to `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation code (see R7) |
| cmd_wdata | input | 8 | Byte to send for a write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | 1 if a device answered the last reset |
| rd_data | output | 8 | Last byte received |
| rom_family | output | 8 | Family byte from the identity read |
| rom_serial | output | 48 | Serial number from the identity read |
| rom_crc | output | 8 | Check byte from the identity read |
| ow_oe | output | 1 | 1 pulls the bus line low |
| ow_in | input | 1 | Bus line level |

## Verification
The hardest thing to reach from the ports is the exact sampling instant. A device that always answers with a long, well-centred pulse cannot tell a master that samples at 70 µs from one that samples tens of microseconds earlier or later.

The bench includes a device model whose presence window and read hold time can be set per test. It narrows the presence pulse to a few microseconds on either side of the 70 µs point. It shortens or lengthens the read hold just before or after the 15 µs point. The expected result flips between those settings.

The identity read needs the model to skip the eight command slots before it answers. The model therefore counts slots from each reset pulse it sees.

// File: rtl/owire_rom_master.sv
module owire_rom_master #(
  parameter int CLK_PER_US = 100,
  parameter int T_RST_LOW  = 480,
  parameter int T_RST_SMP  = 550,
  parameter int T_RST_SLOT = 960,
  parameter int T_W1_LOW   = 6,
  parameter int T_W0_LOW   = 60,
  parameter int T_RD_LOW   = 6,
  parameter int T_RD_SMP   = 15,
  parameter int T_BIT_SLOT = 70,
  parameter logic [7:0] ROM_CMD = 8'h33
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [7:0]  cmd_wdata,
  output logic        busy,
  output logic        done,
  output logic        presence,
  output logic [7:0]  rd_data,
  output logic [7:0]  rom_family,
  output logic [47:0] rom_serial,
  output logic [7:0]  rom_crc,
  output logic        ow_oe,
  input  logic        ow_in
);

  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int UW = $clog2(T_RST_SLOT + 1);
  localparam int ROM_BITS  = 64;
  localparam int ROM_SLOTS = 1 + 8 + ROM_BITS;
  localparam int IW = $clog2(ROM_SLOTS + 1);

  localparam logic [1:0] OP_RST = 2'd0;
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_RD  = 2'd2;
  localparam logic [1:0] OP_ROM = 2'd3;

  localparam logic [1:0] K_RST = 2'd0;
  localparam logic [1:0] K_WR  = 2'd1;
  localparam logic [1:0] K_RD  = 2'd2;

  logic [PW-1:0]       pcnt;
  logic [UW-1:0]       ucnt;
  logic [1:0]          sync;
  logic                busy_q;
  logic                done_q;
  logic                pres_q;
  logic [1:0]          op_q;
  logic [7:0]          txb;
  logic [IW-1:0]       sidx;
  logic [ROM_BITS-1:0] shreg;
  logic [7:0]          rd_q;
  logic [7:0]          fam_q;
  logic [47:0]         ser_q;
  logic [7:0]          crc_q;

  logic [1:0]    kind;
  logic [UW-1:0] low_len;
  logic [UW-1:0] smp_m1;
  logic [UW-1:0] end_m1;
  logic          last;
  logic          tick;
  logic          start;
  logic          sample_now;
  logic          slot_end;

  assign tick  = (pcnt == PW'(CLK_PER_US - 1));
  assign start = cmd_valid && !busy_q;

  always_comb begin
    case (op_q)
      OP_RST:  kind = K_RST;
      OP_WR:   kind = K_WR;
      OP_RD:   kind = K_RD;
      default: kind = (sidx == '0) ? K_RST : ((sidx <= IW'(8)) ? K_WR : K_RD);
    endcase
  end

  always_comb begin
    case (op_q)
      OP_RST:  last = (sidx == '0);
      OP_ROM:  last = (sidx == IW'(ROM_SLOTS - 1));
      default: last = (sidx == IW'(7));
    endcase
  end

  always_comb begin
    case (kind)
      K_RST: begin
        low_len = UW'(T_RST_LOW);
        smp_m1  = UW'(T_RST_SMP - 1);
        end_m1  = UW'(T_RST_SLOT - 1);
      end
      K_WR: begin
        low_len = txb[0] ? UW'(T_W1_LOW) : UW'(T_W0_LOW);
        smp_m1  = '1;
        end_m1  = UW'(T_BIT_SLOT - 1);
      end
      default: begin
        low_len = UW'(T_RD_LOW);
        smp_m1  = UW'(T_RD_SMP - 1);
        end_m1  = UW'(T_BIT_SLOT - 1);
      end
    endcase
  end

  assign sample_now = busy_q && tick && (kind != K_WR) && (ucnt == smp_m1);
  assign slot_end   = busy_q && tick && (ucnt == end_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], ow_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt   <= '0;
      ucnt   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pres_q <= 1'b0;
      op_q   <= OP_RST;
      txb    <= '0;
      sidx   <= '0;
      shreg  <= '0;
      rd_q   <= '0;
      fam_q  <= '0;
      ser_q  <= '0;
      crc_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        op_q   <= cmd_op;
        txb    <= (cmd_op == OP_ROM) ? ROM_CMD : cmd_wdata;
        sidx   <= '0;
        pcnt   <= '0;
        ucnt   <= '0;
      end else if (busy_q) begin
        pcnt <= tick ? '0 : pcnt + 1'b1;
        if (sample_now) begin
          if (kind == K_RST) pres_q <= ~sync[1];
          else               shreg  <= {sync[1], shreg[ROM_BITS-1:1]};
        end
        if (slot_end) begin
          ucnt <= '0;
          if (kind == K_WR) txb <= {1'b0, txb[7:1]};
          if (last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            if (op_q == OP_RD || op_q == OP_ROM) rd_q <= shreg[ROM_BITS-1 -: 8];
            if (op_q == OP_ROM) begin
              fam_q <= shreg[7:0];
              ser_q <= shreg[55:8];
              crc_q <= shreg[63:56];
            end
          end else begin
            sidx <= sidx + 1'b1;
          end
        end else if (tick) begin
          ucnt <= ucnt + 1'b1;
        end
      end
    end
  end

  assign ow_oe      = busy_q && (ucnt < low_len);
  assign busy       = busy_q;
  assign done       = done_q;
  assign presence   = pres_q;
  assign rd_data    = rd_q;
  assign rom_family = fam_q;
  assign rom_serial = ser_q;
  assign rom_crc    = crc_q;

  int unsigned lowrun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowrun <= 0;
    else        lowrun <= ow_oe ? lowrun + 1 : 0;
  end

  // R3, R4, R2: every low pulse has one of the three legal widths
  p_low_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ow_oe) |-> (lowrun == 32'(T_W1_LOW * CLK_PER_US) ||
                      lowrun == 32'(T_W0_LOW * CLK_PER_US) ||
                      lowrun == 32'(T_RST_LOW * CLK_PER_US)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);

  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> ($stable(op_q) && $stable(sidx)));

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !ow_oe);

endmodule

// File: tb/test_owire_rom_master.sv
module test_owire_rom_master;
  localparam int CPU = 4;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_wdata = 8'd0;
  logic busy, done, presence, ow_oe, ow_in;
  logic [7:0] rd_data, rom_family, rom_crc;
  logic [47:0] rom_serial;

  always #5 clk = ~clk;

  owire_rom_master #(.CLK_PER_US(CPU)) i_owire_rom_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .presence(presence),
    .rd_data(rd_data), .rom_family(rom_family), .rom_serial(rom_serial),
    .rom_crc(rom_crc), .ow_oe(ow_oe), .ow_in(ow_in)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  int widths [0:127];
  int rises  [0:127];
  int n_w = 0, n_rise = 0;
  int low_run = 0;
  int busy_cnt = 0, done_cnt = 0;
  logic oe_d = 1'b0;

  int pull_cnt = 0, pres_wait = 0;
  logic dev_here = 1'b1;
  int pres_start = 15, pres_len = 120;
  logic tx_en = 1'b0;
  logic [63:0] tx_bits = '0;
  int tx_skip = 0, slot_no = 0, rd_hold = 30;

  assign ow_in = !(ow_oe || (pull_cnt > 0));

  always @(negedge clk) begin
    cyc++;
    if (busy) busy_cnt++;
    if (done) done_cnt++;
    if (pull_cnt > 0) pull_cnt--;
    if (pres_wait > 0) begin
      pres_wait--;
      if (pres_wait == 0) pull_cnt = pres_len * CPU;
    end
    if (ow_oe) low_run++;
    if (ow_oe && !oe_d) begin
      if (n_rise < 128) rises[n_rise] = cyc;
      n_rise++;
      if (tx_en && slot_no >= tx_skip && slot_no - tx_skip < 64)
        if (!tx_bits[slot_no - tx_skip]) pull_cnt = rd_hold * CPU;
      slot_no++;
    end
    if (!ow_oe && oe_d) begin
      if (n_w < 128) widths[n_w] = low_run;
      n_w++;
      if (low_run >= 400 * CPU) begin
        slot_no = 0;
        if (dev_here) pres_wait = pres_start * CPU;
      end
      low_run = 0;
    end
    oe_d = ow_oe;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    while (!done && cyc < WD_LIMIT) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk);
    n_w = 0; n_rise = 0; busy_cnt = 0; done_cnt = 0;
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic logic [7:0] decode_bits(input int first);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = (widths[first + i] < 30 * CPU);
    return b;
  endfunction

  // {op, data, expected}: writes check the line bits, reads check rd_data
  localparam logic [17:0] VEC [0:7] = '{
    {2'd1, 8'hA5, 8'hA5}, {2'd1, 8'h00, 8'h00}, {2'd1, 8'hFF, 8'hFF}, {2'd1, 8'h33, 8'h33},
    {2'd2, 8'h3C, 8'h3C}, {2'd2, 8'h00, 8'h00}, {2'd2, 8'hFF, 8'hFF}, {2'd2, 8'h81, 8'h81}
  };

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 oe", {63'd0, ow_oe}, 64'd0);
    chk("R1 busy/done/presence", {61'd0, busy, done, presence}, 64'd0);
    chk("R1 data", {rd_data, rom_family, rom_crc}, 64'd0);
    chk("R1 serial", {16'd0, rom_serial}, 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle after release", {62'd0, busy, ow_oe}, 64'd0);

    for (int v = 0; v < 8; v++) begin
      logic [1:0] op;
      logic [7:0] d, e;
      int bad_w, bad_p;
      {op, d, e} = VEC[v];
      tx_en = (op == 2'd2); tx_bits = {56'd0, d}; tx_skip = 0; rd_hold = 30;
      issue(op, d);
      slot_no = 0;
      wait_done();
      if (op == 2'd1) chk("R5 byte on line", {56'd0, decode_bits(0)}, {56'd0, e});
      else            chk("R6 read byte", {56'd0, rd_data}, {56'd0, e});
      bad_w = 0; bad_p = 0;
      for (int i = 0; i < 8; i++) begin
        int expw;
        expw = (op == 2'd1 && !d[i]) ? 60 * CPU : 6 * CPU;
        if (widths[i] != expw) bad_w++;
        if (i > 0 && rises[i] - rises[i-1] != 70 * CPU) bad_p++;
      end
      chk("R3 R4 low widths", bad_w, 0);
      chk("R3 slot period", bad_p, 0);
      chk("R7 busy length", busy_cnt, 8 * 70 * CPU);
      chk("R7 done one cycle", done_cnt, 1);
    end
    tx_en = 1'b0;

    // R6: sample point at 15 us
    tx_en = 1'b1; tx_bits = '0; rd_hold = 12;
    issue(2'd2, 8'h00); slot_no = 0; wait_done();
    chk("R6 release before sample reads 1", {56'd0, rd_data}, 64'hFF);
    rd_hold = 18;
    issue(2'd2, 8'h00); slot_no = 0; wait_done();
    chk("R6 hold past sample reads 0", {56'd0, rd_data}, 64'h00);
    tx_en = 1'b0; rd_hold = 30;

    // R2: reset slot and presence sample point
    dev_here = 1'b0;
    issue(2'd0, 8'h00); wait_done();
    chk("R2 no device", {63'd0, presence}, 64'd0);
    chk("R2 reset low width", widths[0], 480 * CPU);
    chk("R7 reset busy length", busy_cnt, 960 * CPU);
    dev_here = 1'b1; pres_start = 68; pres_len = 4;
    issue(2'd0, 8'h00); wait_done();
    chk("R2 narrow pulse at 70us", {63'd0, presence}, 64'd1);
    pres_start = 60; pres_len = 6;
    issue(2'd0, 8'h00); wait_done();
    chk("R2 pulse before 70us missed", {63'd0, presence}, 64'd0);
    pres_start = 15; pres_len = 120;

    // R8: command while busy is ignored
    tx_en = 1'b1; tx_bits = {56'd0, 8'h5A}; tx_skip = 0;
    issue(2'd2, 8'h00); slot_no = 0;
    repeat (100) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    chk("R8 data kept", {56'd0, rd_data}, 64'h5A);
    chk("R8 length kept", busy_cnt, 8 * 70 * CPU);
    chk("R8 no extra slot", n_w, 8);

    // R9: identity read
    tx_bits = {8'hA7, 48'h665544332211, 8'h01}; tx_skip = 8;
    issue(2'd3, 8'h00);
    wait_done();
    chk("R9 reset first", widths[0], 480 * CPU);
    chk("R9 command 0x33", {56'd0, decode_bits(1)}, 64'h33);
    chk("R9 presence", {63'd0, presence}, 64'd1);
    chk("R9 family", {56'd0, rom_family}, 64'h01);
    chk("R9 serial", {16'd0, rom_serial}, 64'h665544332211);
    chk("R9 check byte", {56'd0, rom_crc}, 64'hA7);
    chk("R9 rd_data is check byte", {56'd0, rd_data}, 64'hA7);
    chk("R9 slot count", n_w, 73);
    chk("R7 identity busy length", busy_cnt, (960 + 72 * 70) * CPU);
    tx_en = 1'b0;

    if (cyc >= WD_LIMIT) chk("watchdog", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(2000000 * 10);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule